// File: doc/BRIEF.md
# DS3/E3 Receive Nibble Payload Interface

This block sits behind a receive framer on a DS3 or E3 line. It takes the recovered serial bit stream one bit per line-clock cycle, together with a frame-start marker that the framer raises on the first bit of each frame. It then delivers the payload to downstream terminal equipment in one of two forms. In nibble mode, payload bits are packed four at a time, first bit in the most significant position, and each completed nibble is announced by a one-cycle strobe. That strobe is the gapped nibble clock, derived from the line clock. In serial mode, each payload bit is forwarded alone with a qualifier. In both modes a one-cycle end-of-frame pulse marks the last bit of every frame.

Three frame formats are supported. The DS3 frame is 4760 bits long, made of 56 blocks of 85 bits. The first bit of each block is overhead and is dropped, which yields 4704 payload bits, or 1176 nibbles. The E3 G.832 frame (4296 bits) and the E3 G.751 frame (1536 bits) pass every bit, giving 1074 and 384 nibbles. Format and mode are sampled only on a frame start. Between frame starts the block keeps counting frame by frame on its own.

A small controller runs three states. S_IDLE waits after reset. S_NIBBLE and S_SERIAL run frames in the named output mode. Every transition happens on frame_start, and the target state follows nib_mode: S_IDLE goes to S_NIBBLE or S_SERIAL, S_NIBBLE goes to S_SERIAL, and S_SERIAL goes to S_NIBBLE. A frame_start that leaves the mode unchanged keeps the state.

Top module: `rxnib_payload_if`

## Requirements
- R1: After reset, and until the first frame_start, nib_stb, ser_vld and eof stay low, and nib_data and ser_data are zero.
- R2: The bit presented with frame_start is bit 0 of a frame. fmt_sel (00 DS3, 01 G.832, 10 or 11 G.751) and nib_mode (1 nibble, 0 serial) are sampled only in that cycle. Changes at other times have no effect on the running frame.
- R3: In DS3 format a frame is 4760 bits. Bit positions that are a multiple of 85 are dropped. A full frame in nibble mode gives exactly 1176 nib_stb pulses.
- R4: In G.832 format a frame is 4296 bits, all passed. A full frame in nibble mode gives exactly 1074 nib_stb pulses.
- R5: In G.751 format a frame is 1536 bits, all passed. A full frame in nibble mode gives exactly 384 nib_stb pulses.
- R6: In nibble mode, the first accepted bit of a nibble appears in nib_data[3] and the fourth in nib_data[0]. nib_stb is high for one cycle, in the cycle after the fourth bit is presented. nib_data changes only together with nib_stb.
- R7: In serial mode, each payload bit appears on ser_data in the next cycle with ser_vld high. ser_vld is low for dropped overhead bits. nib_stb stays low.
- R8: eof is high for exactly one cycle, in the cycle after the last bit of a frame is presented.
- R9: Without a new frame_start, a new frame begins right after the last bit, with the same format and mode.
- R10: A frame_start in the middle of a frame restarts the bit count at 0 and discards a partly assembled nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive line clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_bit | input | 1 | Recovered serial data bit |
| frame_start | input | 1 | High with bit 0 of a frame |
| fmt_sel | input | 2 | Frame format code, sampled on frame_start |
| nib_mode | input | 1 | 1 selects nibble output, 0 serial, sampled on frame_start |
| nib_data | output | 4 | Assembled nibble, first bit in MSB |
| nib_stb | output | 1 | One-cycle gapped nibble clock pulse |
| ser_data | output | 1 | Serial payload bit |
| ser_vld | output | 1 | Qualifies ser_data |
| eof | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions take for granted that frame_start comes from a framer that is already aligned: it is a single-cycle pulse, and no two pulses fall within four bits of each other. They also assume that line_bit presents one new bit in every clock cycle, with no gaps. The stimulus keeps within these limits. Frame starts are placed either on true frame boundaries or, in the restart case, more than a thousand bits into a frame. Data bits come from a free-running shift-register sequence, one bit per cycle.

// File: rtl/rxnib_pkg.sv
package rxnib_pkg;

    typedef enum logic [1:0] {
        FMT_DS3  = 2'd0,
        FMT_G832 = 2'd1,
        FMT_G751 = 2'd2
    } fmt_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_NIBBLE = 2'd1,
        S_SERIAL = 2'd2
    } rx_state_e;

    // Codes 2 and 3 both select the short E3 format.
    function automatic fmt_e decode_fmt(input logic [1:0] code);
        fmt_e f;
        unique case (code)
            2'd0:    f = FMT_DS3;
            2'd1:    f = FMT_G832;
            default: f = FMT_G751;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/rxnib_ctrl.sv
module rxnib_ctrl
    import rxnib_pkg::*;
#(
    parameter int DS3_BITS  = 4760,
    parameter int DS3_BLOCK = 85,
    parameter int G832_BITS = 4296,
    parameter int G751_BITS = 1536
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic [1:0] fmt_sel,
    input  logic       nib_mode,
    output logic       bit_take,
    output logic       nib_path,
    output logic       restart,
    output logic       frame_last,
    output logic       idle
);

    localparam int MAX_BITS = (DS3_BITS > G832_BITS)
                              ? ((DS3_BITS > G751_BITS) ? DS3_BITS : G751_BITS)
                              : ((G832_BITS > G751_BITS) ? G832_BITS : G751_BITS);
    localparam int POS_W = $clog2(MAX_BITS);
    localparam int BLK_W = $clog2(DS3_BLOCK);

    rx_state_e        state_q, state_d;
    fmt_e             fmt_q, fmt_cur;
    logic [POS_W-1:0] pos_q, cur_pos, pos_d;
    logic [BLK_W-1:0] blk_q, cur_blk, blk_d;
    logic             running, is_last, is_oh;

    function automatic logic [POS_W-1:0] last_pos(input fmt_e f);
        logic [POS_W-1:0] r;
        unique case (f)
            FMT_DS3:  r = POS_W'(DS3_BITS - 1);
            FMT_G832: r = POS_W'(G832_BITS - 1);
            default:  r = POS_W'(G751_BITS - 1);
        endcase
        return r;
    endfunction

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: every move happens on a frame start
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (frame_start) state_d = nib_mode ? S_NIBBLE : S_SERIAL;
            end
            S_NIBBLE: begin
                if (frame_start && !nib_mode) state_d = S_SERIAL;
            end
            S_SERIAL: begin
                if (frame_start && nib_mode) state_d = S_NIBBLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Frame position datapath
    always_comb begin
        running = frame_start || (state_q != S_IDLE);
        fmt_cur = frame_start ? decode_fmt(fmt_sel) : fmt_q;
        cur_pos = frame_start ? '0 : pos_q;
        cur_blk = frame_start ? '0 : blk_q;
        is_last = (cur_pos == last_pos(fmt_cur));
        is_oh   = (fmt_cur == FMT_DS3) && (cur_blk == '0);
        pos_d   = is_last ? '0 : cur_pos + POS_W'(1);
        blk_d   = (is_last || cur_blk == BLK_W'(DS3_BLOCK - 1)) ? '0
                                                              : cur_blk + BLK_W'(1);
    end

    // Outputs
    always_comb begin
        bit_take   = running && !is_oh;
        nib_path   = frame_start ? nib_mode : (state_q == S_NIBBLE);
        restart    = frame_start;
        frame_last = running && is_last;
        idle       = (state_q == S_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
            blk_q <= '0;
            fmt_q <= FMT_DS3;
        end else if (running) begin
            pos_q <= pos_d;
            blk_q <= blk_d;
            fmt_q <= fmt_cur;
        end
    end

    AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |-> (pos_q <= last_pos(fmt_q)));  // R9

    AST_BLK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_q < BLK_W'(DS3_BLOCK)));  // R3

endmodule

// File: rtl/rxnib_packer.sv
module rxnib_packer #(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_bit,
    input  logic             bit_take,
    input  logic             nib_path,
    input  logic             restart,
    input  logic             frame_last,
    output logic [NIB_W-1:0] nib_data,
    output logic             nib_stb,
    output logic             ser_data,
    output logic             ser_vld,
    output logic             eof
);

    localparam int CNT_W = $clog2(NIB_W);

    logic [CNT_W-1:0] cnt_q, cnt_eff;
    logic [NIB_W-2:0] sh_q;
    logic             full;

    always_comb begin
        cnt_eff = restart ? '0 : cnt_q;
        full    = (cnt_eff == CNT_W'(NIB_W - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            sh_q     <= '0;
            nib_data <= '0;
            nib_stb  <= 1'b0;
            ser_data <= 1'b0;
            ser_vld  <= 1'b0;
            eof      <= 1'b0;
        end else begin
            nib_stb <= 1'b0;
            ser_vld <= 1'b0;
            eof     <= frame_last;
            if (restart) cnt_q <= '0;
            if (bit_take) begin
                if (nib_path) begin
                    if (full) begin
                        nib_data <= {sh_q, line_bit};
                        nib_stb  <= 1'b1;
                        cnt_q    <= '0;
                    end else begin
                        sh_q  <= {sh_q[NIB_W-3:0], line_bit};
                        cnt_q <= cnt_eff + CNT_W'(1);
                    end
                end else begin
                    ser_data <= line_bit;
                    ser_vld  <= 1'b1;
                end
            end
        end
    end

    // Cycles since the last nibble strobe, for the spacing check
    logic [CNT_W:0] gap_q;
    logic           seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (nib_stb) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_NIB_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        nib_stb |=> !nib_stb);  // R6

    AST_NIB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !nib_stb |-> $stable(nib_data));  // R6

    AST_NIB_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_stb && seen_q) |-> (gap_q >= (CNT_W+1)'(NIB_W - 1)));  // R6

    AST_MODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(nib_stb && ser_vld));  // R7

    AST_EOF_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        eof |=> !eof);  // R8

endmodule

// File: rtl/rxnib_payload_if.sv
module rxnib_payload_if
    import rxnib_pkg::*;
#(
    parameter int DS3_BITS  = 4760,
    parameter int DS3_BLOCK = 85,
    parameter int G832_BITS = 4296,
    parameter int G751_BITS = 1536,
    parameter int NIB_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_bit,
    input  logic             frame_start,
    input  logic [1:0]       fmt_sel,
    input  logic             nib_mode,
    output logic [NIB_W-1:0] nib_data,
    output logic             nib_stb,
    output logic             ser_data,
    output logic             ser_vld,
    output logic             eof
);

    logic bit_take, nib_path, restart, frame_last, idle;

    rxnib_ctrl #(
        .DS3_BITS (DS3_BITS),
        .DS3_BLOCK(DS3_BLOCK),
        .G832_BITS(G832_BITS),
        .G751_BITS(G751_BITS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .fmt_sel    (fmt_sel),
        .nib_mode   (nib_mode),
        .bit_take   (bit_take),
        .nib_path   (nib_path),
        .restart    (restart),
        .frame_last (frame_last),
        .idle       (idle)
    );

    rxnib_packer #(
        .NIB_W(NIB_W)
    ) u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_bit  (line_bit),
        .bit_take  (bit_take),
        .nib_path  (nib_path),
        .restart   (restart),
        .frame_last(frame_last),
        .nib_data  (nib_data),
        .nib_stb   (nib_stb),
        .ser_data  (ser_data),
        .ser_vld   (ser_vld),
        .eof       (eof)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !frame_start) |=> (!eof && !nib_stb && !ser_vld));  // R1

endmodule

// File: tb/rxnib_payload_if_test.sv
module rxnib_payload_if_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_bit = 1'b0;
    logic       frame_start = 1'b0;
    logic [1:0] fmt_sel = 2'd0;
    logic       nib_mode = 1'b0;
    logic [3:0] nib_data;
    logic       nib_stb, ser_data, ser_vld, eof;

    always #4 clk = ~clk;

    rxnib_payload_if uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_bit   (line_bit),
        .frame_start(frame_start),
        .fmt_sel    (fmt_sel),
        .nib_mode   (nib_mode),
        .nib_data   (nib_data),
        .nib_stb    (nib_stb),
        .ser_data   (ser_data),
        .ser_vld    (ser_vld),
        .eof        (eof)
    );

    int errors = 0;
    int checks = 0;
    string tag = "R1";

    // Reference model state
    bit     m_run = 0;
    int     m_fmt = 0;
    bit     m_nib = 0;
    int     m_pos = 0;
    int     m_pbits = 0;
    int     m_pval = 0;
    bit     e_stb = 0, e_sv = 0, e_sd = 0, e_eof = 0;
    int     e_nib = 0;
    int     eof_fmt = 0;
    bit     eof_nib = 0;
    int     stb_cnt = 0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic int flen(input int f);
        if (f == 0) return 4760;
        if (f == 1) return 4296;
        return 1536;
    endfunction

    function automatic int fnibs(input int f);
        if (f == 0) return 1176;
        if (f == 1) return 1074;
        return 384;
    endfunction

    function automatic string freq(input int f);
        if (f == 0) return "R3";
        if (f == 1) return "R4";
        return "R5";
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit next_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // One line-clock cycle: compare, monitor, drive, update model
    task automatic step(input bit b, input bit fs, input logic [1:0] code, input bit nm);
        @(negedge clk);
        chk(tag, "nib_stb", nib_stb, e_stb);
        chk(tag, "nib_data", nib_data, e_nib);
        chk("R7", "ser_vld", ser_vld, e_sv);
        chk("R7", "ser_data", ser_data, e_sd);
        chk("R8", "eof", eof, e_eof);
        if (nib_stb) stb_cnt++;
        if (e_eof) begin
            if (eof_nib) chk(freq(eof_fmt), "nibbles per frame", stb_cnt, fnibs(eof_fmt));
            stb_cnt = 0;
        end
        if (fs) stb_cnt = 0;
        line_bit    = b;
        frame_start = fs;
        fmt_sel     = code;
        nib_mode    = nm;
        // model
        if (fs) begin
            m_run = 1;
            m_fmt = (code == 2'd0) ? 0 : (code == 2'd1) ? 1 : 2;
            m_nib = nm;
            m_pos = 0;
            m_pbits = 0;
            m_pval = 0;
        end
        e_stb = 0;
        e_sv  = 0;
        e_eof = 0;
        if (m_run) begin
            if (!(m_fmt == 0 && (m_pos % 85) == 0)) begin
                if (m_nib) begin
                    m_pval = ((m_pval << 1) | int'(b)) & 15;
                    m_pbits++;
                    if (m_pbits == 4) begin
                        e_nib = m_pval;
                        e_stb = 1;
                        m_pbits = 0;
                        m_pval = 0;
                    end
                end else begin
                    e_sd = b;
                    e_sv = 1;
                end
            end
            if (m_pos == flen(m_fmt) - 1) begin
                e_eof   = 1;
                eof_fmt = m_fmt;
                eof_nib = m_nib;
                m_pos   = 0;
            end else begin
                m_pos++;
            end
        end
    endtask

    task automatic run(input int n, input logic [1:0] code, input bit nm);
        for (int i = 0; i < n; i++) step(next_bit(), 1'b0, code, nm);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "nib_stb at reset", nib_stb, 0);
        chk("R1", "nib_data at reset", nib_data, 0);
        chk("R1", "ser_vld at reset", ser_vld, 0);
        chk("R1", "eof at reset", eof, 0);
        rst_n = 1'b1;
        tag = "R1";
        run(50, 2'd0, 1'b1);

        // R6: known bit pattern at the start of a G.751 nibble frame
        tag = "R6";
        step(1'b1, 1'b1, 2'd2, 1'b1);
        step(1'b0, 1'b0, 2'd2, 1'b1);
        step(1'b0, 1'b0, 2'd2, 1'b1);
        step(1'b0, 1'b0, 2'd2, 1'b1);
        step(1'b0, 1'b0, 2'd2, 1'b1);
        step(1'b1, 1'b0, 2'd2, 1'b1);
        step(1'b1, 1'b0, 2'd2, 1'b1);
        step(1'b1, 1'b0, 2'd2, 1'b1);
        run(1536 - 8, 2'd2, 1'b1);

        // R3: DS3 nibble frame, then R9 flywheel frame
        tag = "R3";
        step(next_bit(), 1'b1, 2'd0, 1'b1);
        run(4760 - 1, 2'd0, 1'b1);
        tag = "R9";
        run(4760, 2'd0, 1'b1);

        // R4: G.832 nibble frame
        tag = "R4";
        step(next_bit(), 1'b1, 2'd1, 1'b1);
        run(4296 - 1, 2'd1, 1'b1);

        // R5: G.751 with code 3, two frames
        tag = "R5";
        step(next_bit(), 1'b1, 2'd3, 1'b1);
        run(2 * 1536 - 1, 2'd3, 1'b1);

        // R7: serial DS3 then serial G.751
        tag = "R7";
        step(next_bit(), 1'b1, 2'd0, 1'b0);
        run(4760 - 1, 2'd0, 1'b0);
        step(next_bit(), 1'b1, 2'd2, 1'b0);
        run(1536 - 1, 2'd2, 1'b0);

        // R2: inputs toggled mid-frame are ignored
        tag = "R2";
        step(next_bit(), 1'b1, 2'd2, 1'b1);
        run(500, 2'd2, 1'b1);
        run(500, 2'd0, 1'b0);
        run(535, 2'd1, 1'b0);

        // R10: restart in the middle of a G.832 frame with a partial nibble
        tag = "R10";
        step(next_bit(), 1'b1, 2'd1, 1'b1);
        run(1001, 2'd1, 1'b1);
        step(next_bit(), 1'b1, 2'd2, 1'b1);
        run(1536 + 8, 2'd2, 1'b1);

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule